// File: doc/BRIEF.md
# Paged MII Register Bank Slave

This block holds thirty-two 16-bit management registers behind a byte-wide serial slave port. A front end that has already decoded bus framing delivers a transaction-start strobe with a register pointer, followed by write bytes or read-byte requests. The block pairs bytes into 16-bit words, high byte first. After each complete word the pointer moves to the next register.

Ten register numbers exist twice: once for the line-side (copper) interface and once for the host-side (fiber) interface. A page register picks which copy the port sees. The bank mixes several bit types: plain read/write bits, read-only bits, bits that latch a fall or a rise until they are read, and bits that clear themselves after a 1 is written. An 8-bit CRC error counter that stops at its maximum is reached only through an index/data register pair. Control bits leave the block as ports, and status bits enter from neighbouring logic.

Top module: `mii_page_regbank`

## Requirements
- R1: A write is two bytes, high byte first. The 16-bit register at the pointer takes the new value at the clock edge that accepts the second byte, and the pointer then advances by one, so four bytes fill two consecutive registers.
- R2: A start strobe loads the pointer and resets the byte phase. A single byte followed by a new start never changes any register, and the next two bytes form a fresh word.
- R3: Register 0 bit 15 (software reset) and bit 9 (negotiation restart) clear themselves. Writing 1 to either raises the matching output (sw_rst_o or an_restart_o) for the selected page for exactly one cycle, after which the bit reads 0. A 1 in bit 15 also clears bits 14 and 11 of that page.
- R4: Register 0 bit 14 (loopback) and bit 11 (power-down) are read/write and drive loopback_o and pwrdn_o for their page copy. Every other bit of register 0 reads 0, and writes to those other bits have no lasting effect.
- R5: Register 1 is read-only. Bit 5 shows the live negotiation-complete input. Bit 4 shows the latched remote fault. Bit 3 always reads 1. Bit 2 shows the latched link status. Other bits read 0, and writes to register 1 change nothing.
- R6: Link status latches low and remote fault latches high. Each holds its captured value until a completed read of register 1 on its page, and that read re-arms it from the live input. Both latches reset to 0.
- R7: Register 22 bits 7:0 hold the page. The value 0x01 selects the fiber copy and every other value selects the copper copy. Bits 15:8 read 0. The paged registers are 0, 1, 4, 5, 6, 7, 8, 17, 18 and 19. The page resets to 0x00.
- R8: Registers 4 to 8 and 17 to 19 are full 16-bit read/write storage, held separately for each page.
- R9: Register 29 is a 16-bit read/write index. With the index at 0x0010, writing register 30 with bit 0 set enables the counter, writing it with bit 0 clear disables the counter and zeroes it, and reading register 30 returns the enable in bit 0. With the index at 0x000C, register 30 reads the count in bits 7:0. Any other index reads 0 and writes have no effect.
- R10: While enabled, the counter adds one for every cycle crc_err_i is high, stops at 255, and never wraps.
- R11: Register numbers outside the bank's map read 0x0000, and writes to them have no effect.
- R12: rd_byte_o changes only on the clock edge that accepts a read request. The first request of a word returns the high byte of a snapshot taken at that edge, and the second returns its low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New transaction strobe; loads the pointer |
| addr_i | input | 5 | Register pointer taken with start_i |
| wr_vld_i | input | 1 | Write byte strobe |
| wr_byte_i | input | 8 | Write byte |
| rd_req_i | input | 1 | Read byte request |
| rd_byte_o | output | 8 | Read byte, valid after the accepting edge |
| an_done_i | input | 2 | Negotiation complete per page (0 copper, 1 fiber) |
| rfault_i | input | 2 | Remote fault per page |
| link_i | input | 2 | Link status per page |
| crc_err_i | input | 1 | One CRC error per high cycle |
| loopback_o | output | 2 | Loopback enable per page |
| pwrdn_o | output | 2 | Power-down per page |
| sw_rst_o | output | 2 | Software reset pulse per page |
| an_restart_o | output | 2 | Negotiation restart pulse per page |

## Verification
All results are registered once. A committed write, a self-clearing pulse and a new page selection take effect at the edge that accepts the second byte. A read byte is due at the edge that accepts its request, and a latch re-arms at the edge that accepts the second read byte. The bench drives strobes at falling edges for one cycle and samples at the falling edge that follows the accepting rising edge, so every value is read half a cycle after it is due. The pulse outputs are sampled there and again one cycle later, to catch a pulse that is missing and one that lasts too long.

// File: rtl/mii_pkg.sv
package mii_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 5;
    localparam int BYTE_W  = 8;
    localparam int NPAGE   = 2;
    localparam int PG_W    = (NPAGE > 1) ? $clog2(NPAGE) : 1;
    localparam int NGEN    = 8;
    localparam int SLOT_W  = $clog2(NGEN);
    localparam int CNT_W   = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PAGE = ADDR_W'(22);
    localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(29);
    localparam logic [ADDR_W-1:0] A_IDAT = ADDR_W'(30);

    localparam logic [REG_W-1:0] IDX_CNT_EN = REG_W'(16'h0010);
    localparam logic [REG_W-1:0] IDX_CNT_RD = REG_W'(16'h000C);
    localparam logic [7:0]       PAGE_FIBER = 8'h01;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // Storage slot for the plain paged read/write registers.
    function automatic slot_t gen_slot(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (a)
            ADDR_W'(4):  s.idx = SLOT_W'(0);
            ADDR_W'(5):  s.idx = SLOT_W'(1);
            ADDR_W'(6):  s.idx = SLOT_W'(2);
            ADDR_W'(7):  s.idx = SLOT_W'(3);
            ADDR_W'(8):  s.idx = SLOT_W'(4);
            ADDR_W'(17): s.idx = SLOT_W'(5);
            ADDR_W'(18): s.idx = SLOT_W'(6);
            ADDR_W'(19): s.idx = SLOT_W'(7);
            default:     s.hit = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mii_byte_xfer.sv
module mii_byte_xfer
    import mii_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_vld_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_req_i,
    input  logic [REG_W-1:0]  rd_word_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [REG_W-1:0]  wr_data_o,
    output logic              rd_done_o,
    output logic [BYTE_W-1:0] rd_byte_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              phase;
        logic [BYTE_W-1:0] msb;
        logic [REG_W-1:0]  snap;
        logic [BYTE_W-1:0] rbyte;
    } xfer_t;

    xfer_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d.ptr   = addr_i;
            state_d.phase = 1'b0;
        end else if (wr_vld_i) begin
            if (!state_q.phase) begin
                state_d.msb   = wr_byte_i;
                state_d.phase = 1'b1;
            end else begin
                state_d.phase = 1'b0;
                state_d.ptr   = state_q.ptr + ADDR_W'(1);
            end
        end else if (rd_req_i) begin
            if (!state_q.phase) begin
                state_d.snap  = rd_word_i;
                state_d.rbyte = rd_word_i[REG_W-1 -: BYTE_W];
                state_d.phase = 1'b1;
            end else begin
                state_d.rbyte = state_q.snap[BYTE_W-1:0];
                state_d.phase = 1'b0;
                state_d.ptr   = state_q.ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ptr_o     = state_q.ptr;
    assign wr_en_o   = wr_vld_i & state_q.phase & ~start_i;
    assign wr_data_o = {state_q.msb, wr_byte_i};
    assign rd_done_o = rd_req_i & state_q.phase & ~start_i & ~wr_vld_i;
    assign rd_byte_o = state_q.rbyte;
endmodule

// File: rtl/mii_latch_bit.sv
module mii_latch_bit #(
    parameter bit HOLD_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic rearm_i,
    output logic val_o
);
    logic val_d, val_q;

    generate
        if (HOLD_HIGH) begin : g_high
            always_comb val_d = rearm_i ? src_i : (val_q | src_i);
        end else begin : g_low
            always_comb val_d = rearm_i ? src_i : (val_q & src_i);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= 1'b0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/mii_err_ctr.sv
module mii_err_ctr
    import mii_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             err_i,
    output logic             en_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_clr_i) begin
            state_d.en  = 1'b0;
            state_d.cnt = '0;
        end else if (en_set_i) begin
            state_d.en = 1'b1;
        end else if (state_q.en && err_i && (state_q.cnt != {CNT_W{1'b1}})) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o  = state_q.en;
    assign cnt_o = state_q.cnt;
endmodule

// File: rtl/mii_page_regbank.sv
module mii_page_regbank
    import mii_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_vld_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_req_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    input  logic [NPAGE-1:0]  an_done_i,
    input  logic [NPAGE-1:0]  rfault_i,
    input  logic [NPAGE-1:0]  link_i,
    input  logic              crc_err_i,
    output logic [NPAGE-1:0]  loopback_o,
    output logic [NPAGE-1:0]  pwrdn_o,
    output logic [NPAGE-1:0]  sw_rst_o,
    output logic [NPAGE-1:0]  an_restart_o
);
    typedef struct packed {
        logic [NPAGE-1:0]                       lb;
        logic [NPAGE-1:0]                       pd;
        logic [NPAGE-1:0]                       srst;
        logic [NPAGE-1:0]                       anr;
        logic [NPAGE-1:0][NGEN-1:0][REG_W-1:0]  gen;
        logic [7:0]                             page;
        logic [REG_W-1:0]                       idx;
    } bank_t;

    bank_t state_d, state_q;

    logic [ADDR_W-1:0] ptr;
    logic              wr_en;
    logic [REG_W-1:0]  wr_data;
    logic              rd_done;
    logic [REG_W-1:0]  rd_word;
    logic [PG_W-1:0]   sel;
    logic [NPAGE-1:0]  link_lat;
    logic [NPAGE-1:0]  rf_lat;
    logic [NPAGE-1:0]  rearm;
    logic              cnt_set;
    logic              cnt_clr;
    logic              cnt_en;
    logic [CNT_W-1:0]  err_cnt;
    slot_t             slot;

    mii_byte_xfer u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .wr_vld_i  (wr_vld_i),
        .wr_byte_i (wr_byte_i),
        .rd_req_i  (rd_req_i),
        .rd_word_i (rd_word),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .rd_done_o (rd_done),
        .rd_byte_o (rd_byte_o)
    );

    assign sel  = (state_q.page == PAGE_FIBER) ? PG_W'(1) : PG_W'(0);
    assign slot = gen_slot(ptr);

    generate
        for (genvar p = 0; p < NPAGE; p++) begin : g_page
            assign rearm[p] = rd_done && (ptr == A_STAT) && (sel == PG_W'(p));

            mii_latch_bit #(.HOLD_HIGH(1'b0)) u_link (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_i   (link_i[p]),
                .rearm_i (rearm[p]),
                .val_o   (link_lat[p])
            );

            mii_latch_bit #(.HOLD_HIGH(1'b1)) u_rf (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_i   (rfault_i[p]),
                .rearm_i (rearm[p]),
                .val_o   (rf_lat[p])
            );
        end
    endgenerate

    assign cnt_set = wr_en && (ptr == A_IDAT) && (state_q.idx == IDX_CNT_EN) &&  wr_data[0];
    assign cnt_clr = wr_en && (ptr == A_IDAT) && (state_q.idx == IDX_CNT_EN) && !wr_data[0];

    mii_err_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set_i (cnt_set),
        .en_clr_i (cnt_clr),
        .err_i    (crc_err_i),
        .en_o     (cnt_en),
        .cnt_o    (err_cnt)
    );

    // Next state of the register file.
    always_comb begin
        state_d      = state_q;
        state_d.srst = '0;
        state_d.anr  = '0;
        if (wr_en) begin
            case (ptr)
                A_CTRL: begin
                    state_d.lb[sel]   = wr_data[14];
                    state_d.pd[sel]   = wr_data[11];
                    state_d.srst[sel] = wr_data[15];
                    state_d.anr[sel]  = wr_data[9];
                    if (wr_data[15]) begin
                        state_d.lb[sel] = 1'b0;
                        state_d.pd[sel] = 1'b0;
                    end
                end
                A_PAGE:  state_d.page = wr_data[7:0];
                A_IDX:   state_d.idx  = wr_data;
                default: begin
                    if (slot.hit) state_d.gen[sel][slot.idx] = wr_data;
                end
            endcase
        end
    end

    // Read word at the pointer.
    always_comb begin
        rd_word = '0;
        case (ptr)
            A_CTRL: rd_word = {state_q.srst[sel], state_q.lb[sel], 1'b0, 1'b0,
                               state_q.pd[sel], 1'b0, state_q.anr[sel], 9'b0};
            A_STAT: rd_word = {10'b0, an_done_i[sel], rf_lat[sel], 1'b1,
                               link_lat[sel], 2'b0};
            A_PAGE: rd_word = {8'b0, state_q.page};
            A_IDX:  rd_word = state_q.idx;
            A_IDAT: begin
                if (state_q.idx == IDX_CNT_EN)
                    rd_word = {{(REG_W-1){1'b0}}, cnt_en};
                else if (state_q.idx == IDX_CNT_RD)
                    rd_word = {{(REG_W-CNT_W){1'b0}}, err_cnt};
            end
            default: begin
                if (slot.hit) rd_word = state_q.gen[sel][slot.idx];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign loopback_o   = state_q.lb;
    assign pwrdn_o      = state_q.pd;
    assign sw_rst_o     = state_q.srst;
    assign an_restart_o = state_q.anr;
endmodule

// File: rtl/mii_regbank_chk.sv
module mii_regbank_chk
    import mii_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_i,
    input logic [BYTE_W-1:0] rd_byte_o,
    input logic [NPAGE-1:0]  link_i,
    input logic [NPAGE-1:0]  link_lat,
    input logic [NPAGE-1:0]  sw_rst_o,
    input logic [NPAGE-1:0]  an_restart_o,
    input logic [CNT_W-1:0]  err_cnt,
    input logic              cnt_clr
);
    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_o[0] |=> !sw_rst_o[0]); // R3
    AST_ANR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o[0] |=> !an_restart_o[0]); // R3
    AST_SRST_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_rst_o)); // R3
    AST_LINK_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !link_i[0] |=> !link_lat[0]); // R6
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_cnt == {CNT_W{1'b1}}) && !cnt_clr) |=> (err_cnt == {CNT_W{1'b1}})); // R10
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (err_cnt >= $past(err_cnt))); // R10
    AST_RDBYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> $stable(rd_byte_o)); // R12
endmodule

bind mii_page_regbank mii_regbank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_i     (rd_req_i),
    .rd_byte_o    (rd_byte_o),
    .link_i       (link_i),
    .link_lat     (link_lat),
    .sw_rst_o     (sw_rst_o),
    .an_restart_o (an_restart_o),
    .err_cnt      (err_cnt),
    .cnt_clr      (cnt_clr)
);

// File: tb/sim_mii_page_regbank.sv
`timescale 1ns/1ps
module sim_mii_page_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] addr_i = '0;
    logic       wr_vld_i = 1'b0;
    logic [7:0] wr_byte_i = '0;
    logic       rd_req_i = 1'b0;
    logic [7:0] rd_byte_o;
    logic [1:0] an_done_i = '0;
    logic [1:0] rfault_i = '0;
    logic [1:0] link_i = '0;
    logic       crc_err_i = 1'b0;
    logic [1:0] loopback_o, pwrdn_o, sw_rst_o, an_restart_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [15:0] mem [2][32];

    always #10 clk = ~clk;

    mii_page_regbank u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .wr_vld_i(wr_vld_i), .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i),
        .rd_byte_o(rd_byte_o), .an_done_i(an_done_i), .rfault_i(rfault_i),
        .link_i(link_i), .crc_err_i(crc_err_i), .loopback_o(loopback_o),
        .pwrdn_o(pwrdn_o), .sw_rst_o(sw_rst_o), .an_restart_o(an_restart_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [4:0] a);
        start_i = 1'b1; addr_i = a;
        tick();
        start_i = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b);
        wr_vld_i = 1'b1; wr_byte_i = b;
        tick();
        wr_vld_i = 1'b0;
    endtask

    task automatic rbyte(output logic [7:0] b);
        rd_req_i = 1'b1;
        tick();
        rd_req_i = 1'b0;
        b = rd_byte_o;
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [15:0] d);
        start(a);
        wbyte(d[15:8]);
        wbyte(d[7:0]);
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [15:0] d);
        logic [7:0] hi, lo;
        start(a);
        rbyte(hi);
        rbyte(lo);
        d = {hi, lo};
    endtask

    task automatic errs(input int n);
        crc_err_i = 1'b1;
        repeat (n) @(negedge clk);
        crc_err_i = 1'b0;
    endtask

    function automatic bit is_gen(input int a);
        return (a >= 4 && a <= 8) || (a >= 17 && a <= 19);
    endfunction

    function automatic bit is_special(input int a);
        return a == 0 || a == 1 || a == 22 || a == 29 || a == 30;
    endfunction

    function automatic logic [15:0] pat(input int pg, input int a);
        return 16'(a * 16'h0101) ^ 16'hA5C3 ^ 16'(pg * 16'h1E00);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b0, b1, b2, b3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R4 reset loopback/pwrdn", {12'b0, loopback_o, pwrdn_o}, 16'h0000);
        read_reg(5'd22, v); chk("R7 reset page", v, 16'h0000);
        read_reg(5'd0, v);  chk("R4 reset ctrl", v, 16'h0000);

        // Sweep: every plain register on both pages
        for (int pg = 0; pg < 2; pg++) begin
            write_reg(5'd22, 16'(pg));
            for (int a = 0; a < 32; a++) begin
                if (!is_special(a)) begin
                    write_reg(5'(a), pat(pg, a));
                    if (is_gen(a)) mem[pg][a] = pat(pg, a);
                end
            end
        end
        for (int pg = 0; pg < 2; pg++) begin
            write_reg(5'd22, 16'(pg));
            for (int a = 0; a < 32; a++) begin
                if (!is_special(a)) begin
                    read_reg(5'(a), v);
                    if (is_gen(a)) chk("R8 paged storage", v, mem[pg][a]);
                    else           chk("R11 unmapped reads zero", v, 16'h0000);
                end
            end
        end

        // Page values other than 0x01 select copper; upper bits read 0
        write_reg(5'd22, 16'hFF02);
        read_reg(5'd22, v); chk("R7 page upper bits", v, 16'h0002);
        read_reg(5'd4, v);  chk("R7 page 0x02 is copper", v, mem[0][4]);
        write_reg(5'd22, 16'h0001);
        read_reg(5'd4, v);  chk("R7 page 0x01 is fiber", v, mem[1][4]);
        write_reg(5'd22, 16'h0000);

        // Auto-increment across two words
        start(5'd17);
        wbyte(8'h12); wbyte(8'h34); wbyte(8'h56); wbyte(8'h78);
        read_reg(5'd17, v); chk("R1 first word", v, 16'h1234);
        read_reg(5'd18, v); chk("R1 second word", v, 16'h5678);
        start(5'd17);
        rbyte(b0); rbyte(b1); rbyte(b2); rbyte(b3);
        chk("R12 read burst", {b0, b1}, 16'h1234);
        chk("R12 read burst next", {b2, b3}, 16'h5678);
        repeat (3) @(negedge clk);
        chk("R12 byte holds while idle", {8'h00, rd_byte_o}, 16'h0078);

        // Lone byte then new start
        start(5'd6); wbyte(8'hEE);
        read_reg(5'd6, v); chk("R2 lone byte ignored", v, mem[0][6]);
        start(5'd7); wbyte(8'h11);
        start(5'd7); wbyte(8'h22); wbyte(8'h33);
        read_reg(5'd7, v); chk("R2 fresh word after start", v, 16'h2233);

        // Control register
        write_reg(5'd0, 16'h4A00);
        chk("R3 restart pulse", {14'b0, an_restart_o}, 16'h0001);
        chk("R4 loopback/pwrdn page0", {12'b0, loopback_o, pwrdn_o}, 16'h0005);
        @(negedge clk);
        chk("R3 restart clears", {14'b0, an_restart_o}, 16'h0000);
        read_reg(5'd0, v); chk("R4 ctrl readback", v, 16'h4800);
        write_reg(5'd22, 16'h0001);
        read_reg(5'd0, v); chk("R4 fiber ctrl separate", v, 16'h0000);
        write_reg(5'd0, 16'h4000);
        chk("R4 fiber loopback", {14'b0, loopback_o}, 16'h0003);
        write_reg(5'd22, 16'h0000);
        write_reg(5'd0, 16'hC800);
        chk("R3 reset pulse", {14'b0, sw_rst_o}, 16'h0001);
        @(negedge clk);
        chk("R3 reset pulse clears", {14'b0, sw_rst_o}, 16'h0000);
        chk("R3 reset clears rw bits", {12'b0, loopback_o, pwrdn_o}, 16'h0008);
        read_reg(5'd0, v); chk("R3 ctrl after reset", v, 16'h0000);
        write_reg(5'd0, 16'h34FF);
        @(negedge clk);
        read_reg(5'd0, v); chk("R4 other bits read 0", v, 16'h0000);

        // Status register and latches
        an_done_i = 2'b01; link_i = 2'b01;
        rfault_i = 2'b01; @(negedge clk); rfault_i = 2'b00;
        @(negedge clk);
        read_reg(5'd1, v); chk("R5 first status read", v, 16'h0038);
        read_reg(5'd1, v); chk("R6 re-armed status", v, 16'h002C);
        link_i = 2'b00; @(negedge clk); link_i = 2'b01;
        @(negedge clk);
        read_reg(5'd1, v); chk("R6 link latched low", v, 16'h0028);
        read_reg(5'd1, v); chk("R6 link re-armed", v, 16'h002C);
        write_reg(5'd1, 16'hFFFF);
        read_reg(5'd1, v); chk("R5 write ignored", v, 16'h002C);
        write_reg(5'd22, 16'h0001);
        read_reg(5'd1, v); chk("R5 fiber status", v, 16'h0008);
        write_reg(5'd22, 16'h0000);

        // Indirect CRC error counter
        write_reg(5'd29, 16'h000C);
        read_reg(5'd29, v); chk("R9 index readback", v, 16'h000C);
        errs(3);
        read_reg(5'd30, v); chk("R9 disabled stays 0", v, 16'h0000);
        write_reg(5'd29, 16'h0010); write_reg(5'd30, 16'h0001);
        read_reg(5'd30, v); chk("R9 enable readback", v, 16'h0001);
        errs(5);
        write_reg(5'd29, 16'h000C);
        read_reg(5'd30, v); chk("R10 count 5", v, 16'h0005);
        errs(300);
        read_reg(5'd30, v); chk("R10 saturate 255", v, 16'h00FF);
        write_reg(5'd29, 16'h0003); write_reg(5'd30, 16'h0000);
        read_reg(5'd30, v); chk("R9 other index reads 0", v, 16'h0000);
        write_reg(5'd29, 16'h000C);
        read_reg(5'd30, v); chk("R9 other index write no effect", v, 16'h00FF);
        write_reg(5'd29, 16'h0010); write_reg(5'd30, 16'h0000);
        errs(4);
        write_reg(5'd29, 16'h000C);
        read_reg(5'd30, v); chk("R9 disable clears", v, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule